// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block maps addresses issued on the host side of a link controller into link-side addresses. It holds a bank of programmable windows. Each window has a control word (enable bit, a 2-bit window type and the low part of an inverted size mask), an extended word with the high 32 bits of that mask, a 4-byte aligned host base and a 64-bit link-side base. Software programs the windows through a simple register write/read port. The host path then presents one 64-bit address per cycle for translation.

Every enabled window compares the incoming address with its host base under its size mask, and all windows do this in parallel. The lowest-numbered window that hits is chosen. Its link base plus the address offset inside the window becomes the translated address, and the result also reports the window type (configuration 0, I/O 1, memory 2) and the window number. For configuration-type windows the bus, device and function numbers held in the link base are reported as separate fields. If no window hits, a miss is flagged and the address is zero. Window 0 is normally set up as the configuration window. Each result appears one cycle after the lookup.

Top module: `owt_xlate`

## Requirements
- R1: After reset every window register reads zero, and `res_valid`, `res_hit` and `res_miss` are low.
- R2: The control word of window w sits at 0x0BA0 + 16*w. Bit 0 is enable and bits 2:1 are the type (0 configuration, 1 I/O, 2 memory). Bits 31:12 hold the low size-mask bits. Bits 11:3 are not stored and read as zero, so the smallest window is 4 KiB.
- R3: The host base of window w sits at 0x0BA4 + 16*w. Bits 1:0 are ignored on write, read back as zero and take no part in matching.
- R4: Link base low and high of window w sit at 0x0BA8 + 16*w and 0x0BAC + 16*w. The extended size word (mask bits 63:32) sits at 0xBAF0 + 4*w. All three hold a full 32 bits. Unmapped addresses read as zero.
- R5: With mask = {ext, ctrl[31:12], 12'b0}, an address A hits an enabled window when (A AND mask) equals (host base AND mask). A disabled window never hits.
- R6: On a hit, `res_addr` equals the 64-bit link base plus (A AND NOT mask), with the carry taken across all 64 bits.
- R7: On a hit, `res_type` equals the type field of the chosen window and `res_win` gives its number.
- R8: When several enabled windows hit, the lowest-numbered one is chosen.
- R9: When no enabled window hits, `res_miss` is 1, `res_hit` is 0, and `res_addr`, `res_type` and `res_win` are zero.
- R10: Each result is presented exactly one cycle after `lookup_valid`. `res_valid` is high only in that cycle, and exactly one of `res_hit` and `res_miss` is high with it.
- R11: A lookup made in the same cycle as a register write uses the window contents from before that write. The write takes effect for lookups from the next cycle on.
- R12: When a configuration-type window hits, `res_bus`, `res_dev` and `res_fn` carry link base low bits 31:24, 23:19 and 18:16. For any other result they are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (combinational) |
| lookup_valid | input | 1 | Host address presented for translation |
| lookup_addr | input | 64 | Host address to translate |
| res_valid | output | 1 | Translation result valid |
| res_hit | output | 1 | A window hit |
| res_miss | output | 1 | No window hit |
| res_win | output | 3 | Number of the chosen window |
| res_type | output | 2 | Type of the chosen window |
| res_addr | output | 64 | Translated link-side address |
| res_bus | output | 8 | Bus number on a configuration hit |
| res_dev | output | 5 | Device number on a configuration hit |
| res_fn | output | 3 | Function number on a configuration hit |

## Verification
A register write and a lookup can happen in the same cycle, and when they do the outcome depends on which window contents the lookup sees. The bench drives a write to the control word or base of a window that the lookup address falls into, or would fall into once the write lands. Examples are disabling the winning window and moving a base under the address. It expects the result computed from the window contents before the write. An immediate second lookup of the same address must then reflect the new contents. Random programming with overlapping windows, mixed with these same-cycle cases, also exercises priority and carry into the upper link-base word.

// File: rtl/owt_pkg.sv
package owt_pkg;

  localparam int WIN_STRIDE = 16;
  localparam int EXT_STRIDE = 4;

  localparam logic [15:0] OFS_CTRL  = 16'h0BA0;
  localparam logic [15:0] OFS_HBASE = 16'h0BA4;
  localparam logic [15:0] OFS_LBLO  = 16'h0BA8;
  localparam logic [15:0] OFS_LBHI  = 16'h0BAC;
  localparam logic [15:0] OFS_EXT   = 16'hBAF0;

  typedef enum logic [1:0] {
    WT_CFG  = 2'd0,
    WT_IO   = 2'd1,
    WT_MEM  = 2'd2,
    WT_RSVD = 2'd3
  } win_type_e;

  typedef struct packed {
    logic        en;
    win_type_e   typ;
    logic [63:0] mask;
    logic [63:0] hbase;
    logic [63:0] lbase;
  } win_cfg_t;

  function automatic logic [15:0] reg_at(logic [15:0] base, int w, int stride);
    return base + 16'(w * stride);
  endfunction

endpackage

// File: rtl/owt_regbank.sv
module owt_regbank
  import owt_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int MIN_LG = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [15:0]           addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output win_cfg_t [NWIN-1:0]   cfg_o
);

  localparam int MLO_W = 32 - MIN_LG;
  localparam int GAP_W = MIN_LG - 3;

  logic [NWIN-1:0]             en_q;
  logic [NWIN-1:0][1:0]        typ_q;
  logic [NWIN-1:0][MLO_W-1:0]  mlo_q;
  logic [NWIN-1:0][29:0]       hb_q;
  logic [NWIN-1:0][31:0]       lbl_q;
  logic [NWIN-1:0][31:0]       lbh_q;
  logic [NWIN-1:0][31:0]       ext_q;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic sel_ctrl, sel_hb, sel_lbl, sel_lbh, sel_ext;

    always_comb begin
      sel_ctrl = we && (addr == reg_at(OFS_CTRL,  w, WIN_STRIDE));
      sel_hb   = we && (addr == reg_at(OFS_HBASE, w, WIN_STRIDE));
      sel_lbl  = we && (addr == reg_at(OFS_LBLO,  w, WIN_STRIDE));
      sel_lbh  = we && (addr == reg_at(OFS_LBHI,  w, WIN_STRIDE));
      sel_ext  = we && (addr == reg_at(OFS_EXT,   w, EXT_STRIDE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[w]  <= 1'b0;
        typ_q[w] <= 2'b00;
        mlo_q[w] <= '0;
      end else if (sel_ctrl) begin
        en_q[w]  <= wdata[0];
        typ_q[w] <= wdata[2:1];
        mlo_q[w] <= wdata[31:MIN_LG];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hb_q[w] <= '0;
      else if (sel_hb) hb_q[w] <= wdata[31:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lbl_q[w] <= '0;
      else if (sel_lbl) lbl_q[w] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lbh_q[w] <= '0;
      else if (sel_lbh) lbh_q[w] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ext_q[w] <= '0;
      else if (sel_ext) ext_q[w] <= wdata;
    end

    always_comb begin
      cfg_o[w].en    = en_q[w];
      cfg_o[w].typ   = win_type_e'(typ_q[w]);
      cfg_o[w].mask  = {ext_q[w], mlo_q[w], {MIN_LG{1'b0}}};
      cfg_o[w].hbase = {32'h0, hb_q[w], 2'b00};
      cfg_o[w].lbase = {lbh_q[w], lbl_q[w]};
    end
  end

  always_comb begin
    rdata = 32'h0;
    for (int w = 0; w < NWIN; w++) begin
      if (addr == reg_at(OFS_CTRL, w, WIN_STRIDE))
        rdata = {mlo_q[w], {GAP_W{1'b0}}, typ_q[w], en_q[w]};
      if (addr == reg_at(OFS_HBASE, w, WIN_STRIDE))
        rdata = {hb_q[w], 2'b00};
      if (addr == reg_at(OFS_LBLO, w, WIN_STRIDE))
        rdata = lbl_q[w];
      if (addr == reg_at(OFS_LBHI, w, WIN_STRIDE))
        rdata = lbh_q[w];
      if (addr == reg_at(OFS_EXT, w, EXT_STRIDE))
        rdata = ext_q[w];
    end
  end

endmodule

// File: rtl/owt_win_match.sv
module owt_win_match (
  input  logic        en,
  input  logic [63:0] mask,
  input  logic [63:0] hbase,
  input  logic [63:0] lbase,
  input  logic [63:0] addr,
  output logic        hit,
  output logic [63:0] xaddr
);

  logic [63:0] offset;
  logic [63:0] diff;

  always_comb begin
    diff   = (addr ^ hbase) & mask;
    offset = addr & ~mask;
    hit    = en && (diff == 64'h0);
    xaddr  = lbase + offset;
  end

endmodule

// File: rtl/owt_prio_pick.sv
module owt_prio_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
  import owt_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int MIN_LG = 12,
  parameter int WIN_IW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [15:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lookup_valid,
  input  logic [63:0]       lookup_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [WIN_IW-1:0] res_win,
  output logic [1:0]        res_type,
  output logic [63:0]       res_addr,
  output logic [7:0]        res_bus,
  output logic [4:0]        res_dev,
  output logic [2:0]        res_fn
);

  logic rst_meta, rst_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  win_cfg_t [NWIN-1:0] cfg;

  owt_regbank #(.NWIN(NWIN), .MIN_LG(MIN_LG)) u_regs (
    .clk   (clk),
    .rst_n (rst_core),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg_o (cfg)
  );

  logic [NWIN-1:0]       hits;
  logic [NWIN-1:0][63:0] xaddrs;

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    owt_win_match u_match (
      .en    (cfg[w].en),
      .mask  (cfg[w].mask),
      .hbase (cfg[w].hbase),
      .lbase (cfg[w].lbase),
      .addr  (lookup_addr),
      .hit   (hits[w]),
      .xaddr (xaddrs[w])
    );
  end

  logic              any_hit;
  logic [WIN_IW-1:0] win_sel;

  owt_prio_pick #(.N(NWIN), .IW(WIN_IW)) u_pick (
    .hits (hits),
    .any  (any_hit),
    .idx  (win_sel)
  );

  logic              valid_d, hit_d, miss_d;
  logic [WIN_IW-1:0] win_d;
  logic [1:0]        type_d;
  logic [63:0]       addr_d;
  logic [7:0]        bus_d;
  logic [4:0]        dev_d;
  logic [2:0]        fn_d;
  logic              res_en;
  win_cfg_t          sel_cfg;

  always_comb begin
    sel_cfg = cfg[win_sel];
    valid_d = lookup_valid;
    hit_d   = lookup_valid && any_hit;
    miss_d  = lookup_valid && !any_hit;
    win_d   = '0;
    type_d  = 2'b00;
    addr_d  = 64'h0;
    bus_d   = 8'h0;
    dev_d   = 5'h0;
    fn_d    = 3'h0;
    if (hit_d) begin
      win_d  = win_sel;
      type_d = sel_cfg.typ;
      addr_d = xaddrs[win_sel];
      if (sel_cfg.typ == WT_CFG) begin
        bus_d = sel_cfg.lbase[31:24];
        dev_d = sel_cfg.lbase[23:19];
        fn_d  = sel_cfg.lbase[18:16];
      end
    end
    res_en = lookup_valid || res_valid;
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_win   <= '0;
      res_type  <= 2'b00;
      res_addr  <= 64'h0;
      res_bus   <= 8'h0;
      res_dev   <= 5'h0;
      res_fn    <= 3'h0;
    end else if (res_en) begin
      res_valid <= valid_d;
      res_hit   <= hit_d;
      res_miss  <= miss_d;
      res_win   <= win_d;
      res_type  <= type_d;
      res_addr  <= addr_d;
      res_bus   <= bus_d;
      res_dev   <= dev_d;
      res_fn    <= fn_d;
    end
  end

endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk #(
  parameter int WIN_IW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lookup_valid,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_miss,
  input logic [WIN_IW-1:0] res_win,
  input logic [1:0]        res_type,
  input logic [63:0]       res_addr,
  input logic [7:0]        res_bus,
  input logic [4:0]        res_dev,
  input logic [2:0]        res_fn
);

  // R10: a result follows every lookup one cycle later
  p_result_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> res_valid);

  // R10: no result without a lookup in the previous cycle
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !res_valid);

  // R10: exactly one of hit and miss with a valid result, neither otherwise
  p_hit_miss_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_hit, res_miss}));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_miss));

  // R9: a miss carries zero address, type and window
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_addr == 64'h0 && res_type == 2'b00 && res_win == '0));

  // R12: device fields are quiet unless a configuration window hit
  p_bdf_cfg_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_hit && res_type == 2'b00) |-> (res_bus == 8'h0 && res_dev == 5'h0 && res_fn == 3'h0));

endmodule

bind owt_xlate owt_xlate_chk #(.WIN_IW(WIN_IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_core),
  .lookup_valid (lookup_valid),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .res_miss     (res_miss),
  .res_win      (res_win),
  .res_type     (res_type),
  .res_addr     (res_addr),
  .res_bus      (res_bus),
  .res_dev      (res_dev),
  .res_fn       (res_fn)
);

// File: tb/owt_xlate_test.sv
module owt_xlate_test;

  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = 16'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        lookup_valid = 1'b0;
  logic [63:0] lookup_addr = 64'h0;
  logic        res_valid, res_hit, res_miss;
  logic [2:0]  res_win;
  logic [1:0]  res_type;
  logic [63:0] res_addr;
  logic [7:0]  res_bus;
  logic [4:0]  res_dev;
  logic [2:0]  res_fn;

  always #10 clk = ~clk;

  owt_xlate uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lookup_valid(lookup_valid),
    .lookup_addr(lookup_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_miss(res_miss), .res_win(res_win), .res_type(res_type),
    .res_addr(res_addr), .res_bus(res_bus), .res_dev(res_dev), .res_fn(res_fn)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] s_ctl [NW];
  logic [31:0] s_hb  [NW];
  logic [31:0] s_ll  [NW];
  logic [31:0] s_lh  [NW];
  logic [31:0] s_ext [NW];

  logic        e_hit;
  logic [2:0]  e_win;
  logic [1:0]  e_type;
  logic [63:0] e_addr;
  logic [15:0] e_bdf;

  function automatic void sh_write(logic [15:0] a, logic [31:0] d);
    for (int w = 0; w < NW; w++) begin
      if (a == 16'h0BA0 + 16'(16*w)) s_ctl[w] = d & 32'hFFFF_F007;
      if (a == 16'h0BA4 + 16'(16*w)) s_hb[w]  = d & 32'hFFFF_FFFC;
      if (a == 16'h0BA8 + 16'(16*w)) s_ll[w]  = d;
      if (a == 16'h0BAC + 16'(16*w)) s_lh[w]  = d;
      if (a == 16'hBAF0 + 16'(4*w))  s_ext[w] = d;
    end
  endfunction

  function automatic void model(logic [63:0] a);
    e_hit = 1'b0; e_win = 3'd0; e_type = 2'd0; e_addr = 64'h0; e_bdf = 16'h0;
    for (int w = 0; w < NW; w++) begin
      logic [63:0] m, b;
      m = {s_ext[w], s_ctl[w][31:12], 12'h000};
      b = {32'h0, s_hb[w]};
      if (!e_hit && s_ctl[w][0] && (((a ^ b) & m) == 64'h0)) begin
        e_hit  = 1'b1;
        e_win  = 3'(w);
        e_type = s_ctl[w][2:1];
        e_addr = {s_lh[w], s_ll[w]} + (a & ~m);
        e_bdf  = (s_ctl[w][2:1] == 2'd0) ? s_ll[w][31:16] : 16'h0;
      end
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    sh_write(a, d);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, "register read", 64'(reg_rdata), 64'(exp));
  endtask

  task automatic judge(input string req);
    logic [63:0] ea, aa;
    ea = {e_hit, !e_hit, e_win, e_type, e_bdf, 4'h0};
    aa = {res_hit, res_miss, res_win, res_type, res_bus, res_dev, res_fn, 4'h0};
    chk(res_valid && ea == aa, req, "result flags/win/type/bdf", aa, ea);
    chk(res_addr == e_addr, req, "translated address", res_addr, e_addr);
  endtask

  task automatic look(input logic [63:0] a, input string req);
    model(a);
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = a;
    @(negedge clk);
    lookup_valid = 1'b0;
    judge(req);
  endtask

  task automatic look_and_write(input logic [63:0] a, input logic [15:0] ra,
                                input logic [31:0] rd, input string req);
    model(a);
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = a;
    reg_we = 1'b1; reg_addr = ra; reg_wdata = rd;
    @(negedge clk);
    lookup_valid = 1'b0; reg_we = 1'b0;
    judge(req);
    sh_write(ra, rd);
    look(a, req);
  endtask

  task automatic prog(input int w, input bit en, input logic [1:0] t,
                      input logic [63:0] mask, input logic [31:0] hb,
                      input logic [63:0] lb);
    wr(16'hBAF0 + 16'(4*w), mask[63:32]);
    wr(16'h0BA4 + 16'(16*w), hb);
    wr(16'h0BA8 + 16'(16*w), lb[31:0]);
    wr(16'h0BAC + 16'(16*w), lb[63:32]);
    wr(16'h0BA0 + 16'(16*w), mask[31:0] | {29'h0, t, en});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0C1A);
    for (int w = 0; w < NW; w++) begin
      s_ctl[w] = 0; s_hb[w] = 0; s_ll[w] = 0; s_lh[w] = 0; s_ext[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(!res_valid && !res_hit && !res_miss, "R1", "result flags after reset",
        64'({res_valid, res_hit, res_miss}), 64'h0);
    for (int w = 0; w < NW; w++) begin
      rd_chk(16'h0BA0 + 16'(16*w), 32'h0, "R1");
      rd_chk(16'h0BA8 + 16'(16*w), 32'h0, "R1");
      rd_chk(16'hBAF0 + 16'(4*w), 32'h0, "R1");
    end

    // R2: control readback drops bits 11:3
    wr(16'h0BA0 + 16'(16*3), 32'hFFFF_FFFF);
    rd_chk(16'h0BA0 + 16'(16*3), 32'hFFFF_F007, "R2");
    wr(16'h0BA0 + 16'(16*3), 32'h0);
    // R3: host base bits 1:0 ignored
    wr(16'h0BA4 + 16'(16*5), 32'h1234_5677);
    rd_chk(16'h0BA4 + 16'(16*5), 32'h1234_5674, "R3");
    // R4: link base and extended size full width, unmapped reads zero
    wr(16'h0BAC + 16'(16*7), 32'hDEAD_BEEF);
    rd_chk(16'h0BAC + 16'(16*7), 32'hDEAD_BEEF, "R4");
    wr(16'hBAF0 + 16'(4*6), 32'hA5A5_5A5A);
    rd_chk(16'hBAF0 + 16'(4*6), 32'hA5A5_5A5A, "R4");
    rd_chk(16'h0B9C, 32'h0, "R4");

    // R9: nothing enabled yet
    look(64'h0000_0000_1234_5678, "R9");

    // R12: config window 0, 4 KiB, bus 3 dev 5 fn 2
    prog(0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_F000, 32'h4000_0000,
         {32'h0000_0001, 8'd3, 5'd5, 3'd2, 16'h0000});
    look(64'h0000_0000_4000_0ABC, "R12");
    // R8: overlapping memory window 1 covering window 0
    prog(1, 1'b1, 2'd2, 64'hFFFF_FFFF_FFF0_0000, 32'h4000_0000, 64'h0000_0080_0000_0000);
    look(64'h0000_0000_4000_0010, "R8");
    look(64'h0000_0000_400F_FFF0, "R7");
    // R5: disabled window never hits
    wr(16'h0BA0, 32'hFFFF_F000);
    look(64'h0000_0000_4000_0010, "R5");
    // R6: carry into the upper link-base word
    prog(2, 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_0000, 32'h8000_0000, 64'h0000_0002_FFFF_F000);
    look(64'h0000_0000_8000_FFFF, "R6");
    // R9: upper host address bits set miss
    look(64'h0000_0001_8000_0010, "R9");
    // R10: no result the cycle after
    @(negedge clk);
    chk(!res_valid, "R10", "valid without lookup", 64'(res_valid), 64'h0);

    // R11: same-cycle write and lookup
    look_and_write(64'h0000_0000_8000_0100, 16'h0BA0 + 16'(16*2), 32'hFFFF_0000, "R11");
    look_and_write(64'h0000_0000_9000_0040, 16'h0BA4 + 16'(16*2), 32'h9000_0000, "R11");
    look_and_write(64'h0000_0000_9000_0040, 16'h0BA0 + 16'(16*2), 32'hFFFF_0003, "R11");

    // random rounds
    for (int r = 0; r < 40; r++) begin
      logic [63:0] sizes [NW];
      for (int w = 0; w < NW; w++) begin
        int lg;
        logic [63:0] sz;
        lg = 12 + int'($urandom % 20);
        sz = 64'h1 << lg;
        sizes[w] = sz;
        prog(w, ($urandom % 4) != 0, 2'($urandom % 3), ~(sz - 64'h1),
             $urandom & ~(32'(sz) - 32'h1), {$urandom, $urandom});
      end
      for (int k = 0; k < 30; k++) begin
        int w;
        logic [63:0] a;
        w = int'($urandom % NW);
        if (($urandom % 5) == 0) a = {($urandom % 2 == 0) ? 32'h0 : $urandom, $urandom};
        else a = {32'h0, s_hb[w]} + ({$urandom, $urandom} & (sizes[w] - 64'h1));
        if (($urandom % 6) == 0)
          look_and_write(a, 16'h0BA0 + 16'(16*w), $urandom, "R11");
        else
          look(a, "R5");
      end
    end

    done = 1'b1;
    summary();
  end

endmodule